// File: doc/BRIEF.md
# Low-Power Escape-Mode Packet Transmitter

This block sends a short command packet over one data lane of a serial display link by driving the lane's two single-ended lines directly, with no help from the high-speed path. A pulse on the start input launches a packet. The block then drives the escape entry code and the low-power data trigger command byte. It next pulls the payload bytes one at a time through a valid/ready handshake, and closes with the exit sequence. Each line state is held for a programmable number of clock cycles.

The output is a set of per-lane override values for the P and N lines plus a common override enable. The pattern is placed on the physical lane chosen by the lane index. That index, the P/N swap flag, the hold interval and the byte count are sampled when the packet starts, so changes to them during a packet have no effect.

Top module: `lp_esc_tx`

## Requirements
- R1: Out of reset and whenever no packet is in progress, ovr_en_o, busy_o, done_o and data_ready_o are 0 and every bit of ovr_p_o and ovr_n_o is 0.
- R2: A packet begins with five line states in the order LP-11, LP-10, LP-00, LP-01, LP-00, where LP-xy means P line = x and N line = y.
- R3: After entry, the command byte 0x87 is sent least significant bit first. A 1 bit is driven as LP-10 and a 0 bit as LP-01, and every bit state is followed by one LP-00 state.
- R4: Each payload byte uses the R3 encoding. data_ready_o rises only once the final LP-00 of the preceding byte has been held for its full interval. The lines then stay at LP-00 until data_valid_i is high, and the byte is taken in the cycle where valid and ready are both 1.
- R5: After the last byte, the lines go LP-00, LP-10, LP-11. In the following cycle all overrides are released, busy_o falls and done_o is 1 for exactly one cycle.
- R6: Each line state lasts exactly H cycles, where H is the hold value sampled at start, and a hold of 0 gives H = 1. The ready wait of R4 adds to the LP-00 that precedes each payload byte.
- R7: When the swap flag sampled at start is 1, LP-10 and LP-01 are exchanged on the lines, while LP-00 and LP-11 are unchanged.
- R8: The P and N values appear only at bit position lane_i (sampled at start) of ovr_p_o and ovr_n_o, and all other bits stay 0.
- R9: A byte count of 0 sends entry, command and exit with no payload byte and never raises data_ready_o.
- R10: A start pulse while a packet is in progress is ignored, and so are changes to lane_i, pn_swap_i, hold_i and byte_count_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Packet launch strobe (used when idle) |
| byte_count_i | input | CNT_W | Number of payload bytes |
| hold_i | input | HOLD_W | Cycles per line state (0 counts as 1) |
| lane_i | input | LANE_W | Physical lane index for the override |
| pn_swap_i | input | 1 | Exchange P and N on the lane |
| data_i | input | 8 | Payload byte |
| data_valid_i | input | 1 | Payload byte valid |
| data_ready_o | output | 1 | Block accepts a payload byte |
| ovr_p_o | output | NUM_LANES | P line override value per lane |
| ovr_n_o | output | NUM_LANES | N line override value per lane |
| ovr_en_o | output | 1 | Override enable |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse at packet end |

## Verification
Packets are compared as run-length sequences of the enable and line pair on the chosen lane. Both the bit order and the merging of adjacent LP-00 states are visible in that form. An empty packet exercises the entry-to-exit join on its own. Payloads of alternating and all-equal bytes separate LSB-first from MSB-first order and a 1-bit mapping from a 0-bit mapping. Runs with the swap flag on odd lanes and with hold 0 show whether the exchange and the zero-to-one rule are applied. One packet stalls valid for several cycles and pulses start and a new hold mid-flight, which exposes both a sequencer that does not wait and one that re-samples its settings.

// File: rtl/lp_esc_pkg.sv
package lp_esc_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_IDX_W = $clog2(BYTE_W);

   // line pair {P, N}
   typedef logic [1:0] line_t;
   localparam line_t LP_00 = 2'b00;
   localparam line_t LP_01 = 2'b01;
   localparam line_t LP_10 = 2'b10;
   localparam line_t LP_11 = 2'b11;

   localparam logic [BYTE_W-1:0] CMD_LPDT = 8'h87;
   localparam logic [2:0] ENTRY_LAST = 3'd4;
   localparam logic [2:0] EXIT_LAST = 3'd2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ENTRY,
      PH_BIT,
      PH_SPACE,
      PH_WAIT,
      PH_EXIT
   } phase_t;

   function automatic line_t entry_sym(input logic [2:0] i);
      case (i)
         3'd0:    return LP_11;
         3'd1:    return LP_10;
         3'd3:    return LP_01;
         default: return LP_00;
      endcase
   endfunction

   function automatic line_t exit_sym(input logic [2:0] i);
      case (i)
         3'd0:    return LP_00;
         3'd1:    return LP_10;
         default: return LP_11;
      endcase
   endfunction

   function automatic line_t bit_sym(input logic b);
      return b ? LP_10 : LP_01;
   endfunction

endpackage

// File: rtl/lp_hold_timer.sv
module lp_hold_timer #(
   parameter int HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic              expire_o
);

   localparam logic [HOLD_W-1:0] ONE_H = 1;

   logic [HOLD_W-1:0] cnt_q;
   logic [HOLD_W-1:0] eff;

   assign eff = (hold_i == '0) ? ONE_H : hold_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= ONE_H;
      else if (load_i)         cnt_q <= eff;
      else if (cnt_q > ONE_H)  cnt_q <= cnt_q - ONE_H;
   end

   assign expire_o = (cnt_q == ONE_H);

   // counter never reaches zero, so every state lasts at least one cycle
   a_r6_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0);

endmodule

// File: rtl/lp_esc_seq.sv
module lp_esc_seq
   import lp_esc_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int HOLD_W = 8,
   parameter int LANE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  byte_count_i,
   input  logic [HOLD_W-1:0] hold_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic              swap_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              valid_i,
   output logic              ready_o,
   input  logic              expire_i,
   output logic              load_o,
   output logic [HOLD_W-1:0] hold_sel_o,
   output line_t             sym_o,
   output logic              active_o,
   output logic              done_o,
   output logic [LANE_W-1:0] lane_o,
   output logic              swap_o
);

   localparam logic [CNT_W-1:0] ONE_C = 1;
   localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

   phase_t               state_q, state_d;
   logic [2:0]           idx_q, idx_d;
   logic [CNT_W-1:0]     rem_q, rem_d;
   logic [BYTE_W-1:0]    shr_q, shr_d;
   line_t                sym_q, sym_d;
   logic                 done_q, done_d;
   logic [HOLD_W-1:0]    hold_q;
   logic [LANE_W-1:0]    lane_q;
   logic                 swap_q;
   logic                 load;

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      rem_d   = rem_q;
      shr_d   = shr_q;
      sym_d   = sym_q;
      done_d  = 1'b0;
      load    = 1'b0;
      unique case (state_q)
         PH_IDLE: if (start_i) begin
            state_d = PH_ENTRY;
            idx_d   = 3'd0;
            sym_d   = entry_sym(3'd0);
            shr_d   = CMD_LPDT;
            rem_d   = byte_count_i;
            load    = 1'b1;
         end
         PH_ENTRY: if (expire_i) begin
            load = 1'b1;
            if (idx_q == ENTRY_LAST) begin
               state_d = PH_BIT;
               idx_d   = 3'd0;
               sym_d   = bit_sym(shr_q[0]);
            end else begin
               idx_d = idx_q + 3'd1;
               sym_d = entry_sym(idx_q + 3'd1);
            end
         end
         PH_BIT: if (expire_i) begin
            load    = 1'b1;
            state_d = PH_SPACE;
            sym_d   = LP_00;
         end
         PH_SPACE: if (expire_i) begin
            if (idx_q[BIT_IDX_W-1:0] != LAST_BIT) begin
               load    = 1'b1;
               state_d = PH_BIT;
               idx_d   = idx_q + 3'd1;
               sym_d   = bit_sym(shr_q[idx_q + 3'd1]);
            end else if (rem_q != '0) begin
               state_d = PH_WAIT;
            end else begin
               load    = 1'b1;
               state_d = PH_EXIT;
               idx_d   = 3'd0;
               sym_d   = exit_sym(3'd0);
            end
         end
         PH_WAIT: if (valid_i) begin
            load    = 1'b1;
            state_d = PH_BIT;
            idx_d   = 3'd0;
            shr_d   = data_i;
            rem_d   = rem_q - ONE_C;
            sym_d   = bit_sym(data_i[0]);
         end
         PH_EXIT: if (expire_i) begin
            if (idx_q == EXIT_LAST) begin
               state_d = PH_IDLE;
               sym_d   = LP_00;
               done_d  = 1'b1;
            end else begin
               load  = 1'b1;
               idx_d = idx_q + 3'd1;
               sym_d = exit_sym(idx_q + 3'd1);
            end
         end
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         idx_q   <= '0;
         rem_q   <= '0;
         shr_q   <= '0;
         sym_q   <= LP_00;
         done_q  <= 1'b0;
         hold_q  <= '0;
         lane_q  <= '0;
         swap_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         rem_q   <= rem_d;
         shr_q   <= shr_d;
         sym_q   <= sym_d;
         done_q  <= done_d;
         if (state_q == PH_IDLE && start_i) begin
            hold_q <= hold_i;
            lane_q <= lane_i;
            swap_q <= swap_i;
         end
      end
   end

   assign hold_sel_o = (state_q == PH_IDLE) ? hold_i : hold_q;
   assign load_o     = load;
   assign sym_o      = sym_q;
   assign active_o   = (state_q != PH_IDLE);
   assign done_o     = done_q;
   assign ready_o    = (state_q == PH_WAIT);
   assign lane_o     = lane_q;
   assign swap_o     = swap_q;

   // R4: ready is only offered while the line sits at LP-00
   a_r4_ready_at_space: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (sym_q == LP_00));

   // R6: line state moves only when the hold timer expires
   a_r6_hold_respected: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && state_q != PH_WAIT && !expire_i) |=> $stable(sym_q));

   // R5: done marks the cycle right after the last active cycle
   a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!active_o && $past(active_o)));

   // R10: settings stay frozen while a packet runs
   a_r10_settings_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && $past(active_o)) |-> ($stable(lane_q) && $stable(swap_q) && $stable(hold_q)));

endmodule

// File: rtl/lp_lane_map.sv
module lp_lane_map
   import lp_esc_pkg::*;
#(
   parameter int NUM_LANES = 5,
   parameter int LANE_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  line_t                sym_i,
   input  logic                 swap_i,
   input  logic [LANE_W-1:0]    lane_i,
   input  logic                 active_i,
   output logic [NUM_LANES-1:0] ovr_p_o,
   output logic [NUM_LANES-1:0] ovr_n_o,
   output logic                 ovr_en_o
);

   line_t line;

   // swap only exchanges the two unequal states; equal pairs are symmetric
   assign line = swap_i ? {sym_i[0], sym_i[1]} : sym_i;

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      logic sel;
      assign sel        = active_i && (lane_i == LANE_W'(k));
      assign ovr_p_o[k] = sel && line[1];
      assign ovr_n_o[k] = sel && line[0];
   end

   assign ovr_en_o = active_i;

   // R8: at most one lane carries the pattern
   a_r8_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ovr_p_o) && $onehot0(ovr_n_o));

   // R1: released overrides read as zero
   a_r1_release_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_en_o |-> (ovr_p_o == '0 && ovr_n_o == '0));

endmodule

// File: rtl/lp_esc_tx.sv
module lp_esc_tx
   import lp_esc_pkg::*;
#(
   parameter int NUM_LANES = 5,
   parameter int CNT_W     = 8,
   parameter int HOLD_W    = 8,
   parameter int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [CNT_W-1:0]     byte_count_i,
   input  logic [HOLD_W-1:0]    hold_i,
   input  logic [LANE_W-1:0]    lane_i,
   input  logic                 pn_swap_i,
   input  logic [7:0]           data_i,
   input  logic                 data_valid_i,
   output logic                 data_ready_o,
   output logic [NUM_LANES-1:0] ovr_p_o,
   output logic [NUM_LANES-1:0] ovr_n_o,
   output logic                 ovr_en_o,
   output logic                 busy_o,
   output logic                 done_o
);

   if (NUM_LANES < 1 || NUM_LANES > 32) begin : g_bad_lanes
      $error("lp_esc_tx: NUM_LANES out of range");
   end
   if (HOLD_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("lp_esc_tx: counter widths must be positive");
   end
   if ((1 << LANE_W) < NUM_LANES) begin : g_bad_lane_w
      $error("lp_esc_tx: LANE_W too narrow for NUM_LANES");
   end

   logic              expire;
   logic              load;
   logic [HOLD_W-1:0] hold_sel;
   line_t             sym;
   logic              active;
   logic [LANE_W-1:0] lane_q;
   logic              swap_q;

   lp_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .hold_i   (hold_sel),
      .expire_o (expire)
   );

   lp_esc_seq #(.CNT_W(CNT_W), .HOLD_W(HOLD_W), .LANE_W(LANE_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .byte_count_i (byte_count_i),
      .hold_i       (hold_i),
      .lane_i       (lane_i),
      .swap_i       (pn_swap_i),
      .data_i       (data_i),
      .valid_i      (data_valid_i),
      .ready_o      (data_ready_o),
      .expire_i     (expire),
      .load_o       (load),
      .hold_sel_o   (hold_sel),
      .sym_o        (sym),
      .active_o     (active),
      .done_o       (done_o),
      .lane_o       (lane_q),
      .swap_o       (swap_q)
   );

   lp_lane_map #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_i    (sym),
      .swap_i   (swap_q),
      .lane_i   (lane_q),
      .active_i (active),
      .ovr_p_o  (ovr_p_o),
      .ovr_n_o  (ovr_n_o),
      .ovr_en_o (ovr_en_o)
   );

   assign busy_o = active;

   // R9: a payload request never coexists with an idle block
   a_r9_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready_o |-> busy_o);

endmodule

// File: tb/lp_esc_tx_test.sv
module lp_esc_tx_test;

   localparam int NL = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [7:0]    byte_count_i = '0;
   logic [7:0]    hold_i = '0;
   logic [2:0]    lane_i = '0;
   logic          pn_swap_i = 1'b0;
   logic [7:0]    data_i = '0;
   logic          data_valid_i = 1'b0;
   logic          data_ready_o;
   logic [NL-1:0] ovr_p_o, ovr_n_o;
   logic          ovr_en_o, busy_o, done_o;

   always #2 clk = ~clk;   // 250 MHz

   lp_esc_tx #(.NUM_LANES(NL)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
      .hold_i(hold_i), .lane_i(lane_i), .pn_swap_i(pn_swap_i), .data_i(data_i),
      .data_valid_i(data_valid_i), .data_ready_o(data_ready_o), .ovr_p_o(ovr_p_o),
      .ovr_n_o(ovr_n_o), .ovr_en_o(ovr_en_o), .busy_o(busy_o), .done_o(done_o)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // expected runs: {en,P,N} and length
   logic [2:0] exp_v[$];
   int         exp_d[$];
   int         lane_chk = 0;
   logic [7:0] pay [0:3];

   function automatic logic [2:0] sw(input logic [2:0] v, input bit s);
      if (s && v[1] != v[0]) return {v[2], v[0], v[1]};
      return v;
   endfunction

   function automatic void add_run(input logic [2:0] v, input int d);
      if (exp_v.size() != 0 && exp_v[exp_v.size()-1] == v)
         exp_d[exp_v.size()-1] = exp_d[exp_v.size()-1] + d;
      else begin
         exp_v.push_back(v);
         exp_d.push_back(d);
      end
   endfunction

   function automatic void add_byte(input logic [7:0] b, input int h, input bit s);
      for (int i = 0; i < 8; i++) begin
         add_run(sw(b[i] ? 3'b110 : 3'b101, s), h);   // R3 1->LP-10, 0->LP-01
         add_run(3'b100, h);
      end
   endfunction

   // monitor / scoreboard
   logic [2:0] prev = 3'b000;
   int         run_len = 0;
   bit         stray = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [2:0] cur;
         logic [NL-1:0] others;
         cur = {ovr_en_o, ovr_p_o[lane_chk], ovr_n_o[lane_chk]};
         others = (ovr_p_o | ovr_n_o) & ~(NL'(1) << lane_chk);
         if (others != '0) stray = 1;
         if (data_ready_o && cur != 3'b100) begin
            fails++;
            $display("FAIL R4 ready with line %b expected 100", cur);
         end
         if (busy_o != ovr_en_o) begin
            fails++;
            $display("FAIL R5 busy %b expected %b", busy_o, ovr_en_o);
         end
         if (cur == prev) run_len++;
         else begin
            if (prev[2]) begin
               checks++;
               if (exp_v.size() == 0) begin
                  fails++;
                  $display("FAIL R2 unexpected run %b len %0d expected none", prev, run_len);
               end else begin
                  logic [2:0] ev;
                  int ed;
                  ev = exp_v.pop_front();
                  ed = exp_d.pop_front();
                  if (ev != prev || ed != run_len) begin
                     fails++;
                     $display("FAIL R2/R3/R4/R6/R7 run %b len %0d expected %b len %0d",
                              prev, run_len, ev, ed);
                  end
               end
               checks++;
               if (stray) begin
                  fails++;
                  $display("FAIL R8 other lane driven, got 1 expected 0");
               end
               stray = 0;
               if (!cur[2]) begin
                  checks++;
                  if (done_o !== 1'b1) begin
                     fails++;
                     $display("FAIL R5 done %b expected 1", done_o);
                  end
               end
            end else if (done_o) begin
               fails++;
               $display("FAIL R5 done %b expected 0", done_o);
            end
            prev = cur;
            run_len = 1;
         end
      end
   end

   task automatic send(input int cnt, input int lane, input bit s, input int hold,
                       input int gap, input bit poke);
      int h;
      h = (hold == 0) ? 1 : hold;   // R6 zero counts as one
      lane_chk = lane;
      add_run(3'b111, h);            // R2 entry
      add_run(sw(3'b110, s), h);
      add_run(3'b100, h);
      add_run(sw(3'b101, s), h);
      add_run(3'b100, h);
      add_byte(8'h87, h, s);         // R3 command
      for (int i = 0; i < cnt; i++) begin
         add_run(3'b100, gap + 1);   // R4 ready wait
         add_byte(pay[i], h, s);
      end
      add_run(3'b100, h);            // R5 exit
      add_run(sw(3'b110, s), h);
      add_run(3'b111, h);
      @(negedge clk);
      lane_i = 3'(lane); pn_swap_i = s; hold_i = 8'(hold); byte_count_i = 8'(cnt);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin                // R10 disturbances mid-packet
         repeat (3) @(negedge clk);
         start_i = 1'b1; hold_i = 8'(hold + 7); lane_i = 3'((lane + 1) % NL);
         pn_swap_i = ~s; byte_count_i = 8'(cnt + 2);
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int i = 0; i < cnt; i++) begin
         while (!data_ready_o) @(negedge clk);
         repeat (gap) @(negedge clk);
         data_i = pay[i]; data_valid_i = 1'b1;
         @(negedge clk);
         data_valid_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      repeat (3) @(negedge clk);
      checks++;
      if (exp_v.size() != 0) begin
         fails++;
         $display("FAIL R5 leftover runs %0d expected 0", exp_v.size());
         exp_v.delete(); exp_d.delete();
      end
      checks++;
      if (ovr_p_o != '0 || ovr_n_o != '0 || data_ready_o) begin
         fails++;
         $display("FAIL R1 idle outputs p=%b n=%b rdy=%b expected 0", ovr_p_o, ovr_n_o, data_ready_o);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;   // R1 reset state
      if (ovr_p_o != '0 || ovr_n_o != '0 || ovr_en_o || busy_o || done_o || data_ready_o) begin
         fails++;
         $display("FAIL R1 reset outputs p=%b n=%b en=%b expected all 0", ovr_p_o, ovr_n_o, ovr_en_o);
      end
      // R9 empty packet
      send(0, 0, 0, 1, 0, 0);
      // R8 lane 2, two bytes
      pay[0] = 8'hA5; pay[1] = 8'h3C;
      send(2, 2, 0, 3, 0, 0);
      // R7 swap on lane 4 with hold 0
      pay[0] = 8'h5A;
      send(1, 4, 1, 0, 0, 0);
      // R4 stall plus R10 disturbances
      pay[0] = 8'hFF; pay[1] = 8'h00;
      send(2, 1, 0, 2, 4, 1);
      // R6 longer hold, swap, three bytes
      pay[0] = 8'h01; pay[1] = 8'h80; pay[2] = 8'hC3;
      send(3, 3, 1, 5, 1, 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired, got hang expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule